// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the architectural registers of a small 16-bit core. It has two combinational read ports and one write port, and each port is addressed with a 3-bit register code. Codes 0 to 3 always name four general registers that both privilege levels share. The meaning of codes 4 to 7 depends on the privilege mode, which is a bit inside the status register. In kernel mode these codes reach the system registers: instruction pointer, stack pointer, return address and status. In user mode the same codes reach four general registers that belong to user mode only.

Each port has its own override bit. Stack and segment operations set it so that they reach the system bank even while the core runs in user mode. The core also needs a full-width load of the 24-bit instruction pointer and a segment update that touches only the low byte of status, so the block has a dedicated input for each. The instruction pointer and the status word are also driven out continuously, so the fetch and condition logic can use them.

Top module: `bankreg_file`

## Requirements
- R1: Codes 0-3 select the same four shared registers in both modes, on reads and on writes.
- R2: In kernel mode, code 4 reads the low 16 bits of the instruction pointer, code 5 the stack pointer, code 6 the return-address register and code 7 the status word (equal to `status_o`).
- R3: In user mode without override, codes 4-7 select four user-only registers whose contents are separate from the system registers.
- R4: When a port's override bit is 1, codes 4-7 on that port select the system registers even in user mode, for reads and for writes.
- R5: Status bit 12 is the mode (1 kernel, 0 user). Bits 15..13 are flags, bits 11..8 a process id and bits 7..0 the segment. A write to status changes the bank mapping from the next cycle on.
- R6: The instruction pointer is 24 bits. `ip_load_i` loads all 24 bits from `ip_data_i`. A port write to the instruction pointer replaces only its low 16 bits. `ip_o` changes only through these two paths.
- R7: `seg_wr_i` replaces status bits 7..0 with `seg_data_i` and leaves bits 15..8 unchanged.
- R8: A read of a register that is written in the same cycle returns the old value. The write takes effect at the next rising clock edge.
- R9: An asynchronous low `rst_ni` clears every register and sets status to 16'h1000 (kernel mode).
- R10: The two read ports decode independently and may address the same or different registers in the same cycle.
- R11: A full instruction-pointer load in the same cycle as a port write to it wins. In the same cycle as a port write to status, a segment write sets bits 7..0 and the port write sets bits 15..8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_a_addr_i | input | 3 | Read port A register code |
| rd_a_sys_i | input | 1 | Read port A system-bank override |
| rd_a_data_o | output | 16 | Read port A data |
| rd_b_addr_i | input | 3 | Read port B register code |
| rd_b_sys_i | input | 1 | Read port B system-bank override |
| rd_b_data_o | output | 16 | Read port B data |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 3 | Write register code |
| wr_sys_i | input | 1 | Write system-bank override |
| wr_data_i | input | 16 | Write data |
| ip_load_i | input | 1 | Full instruction-pointer load |
| ip_data_i | input | 24 | Instruction-pointer load value |
| seg_wr_i | input | 1 | Segment field update |
| seg_data_i | input | 8 | New segment value |
| ip_o | output | 24 | Current instruction pointer |
| status_o | output | 16 | Current status word |

## Verification
The same codes 4-7 are read and written in kernel mode, in user mode, and in user mode with the override set. The stack pointer, return address and status hold values that are distinct from those in the user registers, so a wrong bank selection shows up as a wrong value. Codes 0-3 are read on both sides of a mode switch to show that they are shared. Reads of a register in the same cycle as a write to it show that the old value is returned. Simultaneous instruction-pointer and status updates from two sources tell apart which source wins, and show that only the intended bit fields change.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;
  localparam int DATA_W   = 16;
  localparam int IP_W     = 24;
  localparam int CODE_W   = 3;
  localparam int BANK_N   = 4;
  localparam int IDX_W    = $clog2(BANK_N);
  localparam int SEG_W    = 8;
  localparam int MODE_BIT = 12;

  localparam logic [DATA_W-1:0] STATUS_RST = DATA_W'(1) << MODE_BIT;

  // system bank slot order is fixed by the code decode
  localparam logic [IDX_W-1:0] SYS_IP = 2'd0;
  localparam logic [IDX_W-1:0] SYS_SP = 2'd1;
  localparam logic [IDX_W-1:0] SYS_RA = 2'd2;
  localparam logic [IDX_W-1:0] SYS_ST = 2'd3;

  typedef enum logic [1:0] {
    BANK_SHARED = 2'd0,
    BANK_USER   = 2'd1,
    BANK_SYS    = 2'd2
  } bank_e;

  typedef struct packed {
    bank_e            bank;
    logic [IDX_W-1:0] idx;
  } reg_sel_t;
endpackage

// File: rtl/bankreg_decode.sv
module bankreg_decode
  import bankreg_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  input  logic              kernel_i,
  input  logic              sys_i,
  output reg_sel_t          sel_o
);
  always_comb begin
    sel_o.idx = code_i[IDX_W-1:0];
    if (!code_i[CODE_W-1])     sel_o.bank = BANK_SHARED;
    else if (kernel_i || sys_i) sel_o.bank = BANK_SYS;
    else                        sel_o.bank = BANK_USER;
  end
endmodule

// File: rtl/bankreg_gpr_bank.sv
module bankreg_gpr_bank #(
  parameter int N = 4,
  parameter int W = 16,
  localparam int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic [IW-1:0] rd_a_idx_i,
  input  logic [IW-1:0] rd_b_idx_i,
  output logic [W-1:0]  rd_a_o,
  output logic [W-1:0]  rd_b_o
);
  logic [W-1:0] regs_q [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   regs_q[g] <= '0;
      else if (wr_en_i && wr_idx_i == IW'(g))        regs_q[g] <= wr_data_i;
    end
  end

  assign rd_a_o = regs_q[rd_a_idx_i];
  assign rd_b_o = regs_q[rd_b_idx_i];
endmodule

// File: rtl/bankreg_sys_bank.sv
module bankreg_sys_bank
  import bankreg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              ip_load_i,
  input  logic [IP_W-1:0]   ip_data_i,
  input  logic              seg_wr_i,
  input  logic [SEG_W-1:0]  seg_data_i,
  input  logic [IDX_W-1:0]  rd_a_idx_i,
  input  logic [IDX_W-1:0]  rd_b_idx_i,
  output logic [DATA_W-1:0] rd_a_o,
  output logic [DATA_W-1:0] rd_b_o,
  output logic [IP_W-1:0]   ip_o,
  output logic [DATA_W-1:0] status_o
);
  logic [IP_W-1:0]   ip_q, ip_d;
  logic [DATA_W-1:0] sp_q, ra_q, st_q, st_d;
  logic [DATA_W-1:0] view [BANK_N];

  always_comb begin
    ip_d = ip_q;
    if (ip_load_i)                         ip_d = ip_data_i;
    else if (wr_en_i && wr_idx_i == SYS_IP) ip_d = {ip_q[IP_W-1:DATA_W], wr_data_i};
  end

  always_comb begin
    st_d = st_q;
    if (wr_en_i && wr_idx_i == SYS_ST) st_d = wr_data_i;
    // segment field update overrides the low byte only
    if (seg_wr_i) st_d[SEG_W-1:0] = seg_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ip_q <= '0;
      sp_q <= '0;
      ra_q <= '0;
      st_q <= STATUS_RST;
    end else begin
      ip_q <= ip_d;
      st_q <= st_d;
      if (wr_en_i && wr_idx_i == SYS_SP) sp_q <= wr_data_i;
      if (wr_en_i && wr_idx_i == SYS_RA) ra_q <= wr_data_i;
    end
  end

  assign view[SYS_IP] = ip_q[DATA_W-1:0];
  assign view[SYS_SP] = sp_q;
  assign view[SYS_RA] = ra_q;
  assign view[SYS_ST] = st_q;

  assign rd_a_o   = view[rd_a_idx_i];
  assign rd_b_o   = view[rd_b_idx_i];
  assign ip_o     = ip_q;
  assign status_o = st_q;
endmodule

// File: rtl/bankreg_file.sv
module bankreg_file
  import bankreg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] rd_a_addr_i,
  input  logic              rd_a_sys_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [CODE_W-1:0] rd_b_addr_i,
  input  logic              rd_b_sys_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  input  logic              wr_en_i,
  input  logic [CODE_W-1:0] wr_addr_i,
  input  logic              wr_sys_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              ip_load_i,
  input  logic [IP_W-1:0]   ip_data_i,
  input  logic              seg_wr_i,
  input  logic [SEG_W-1:0]  seg_data_i,
  output logic [IP_W-1:0]   ip_o,
  output logic [DATA_W-1:0] status_o
);
  localparam int NPORT = 3; // 0: read A, 1: read B, 2: write

  logic              kernel;
  logic [CODE_W-1:0] code [NPORT];
  logic              ovr  [NPORT];
  reg_sel_t          sel  [NPORT];
  logic [DATA_W-1:0] shr_a, shr_b, usr_a, usr_b, sys_a, sys_b;

  assign kernel  = status_o[MODE_BIT];
  assign code[0] = rd_a_addr_i;
  assign code[1] = rd_b_addr_i;
  assign code[2] = wr_addr_i;
  assign ovr[0]  = rd_a_sys_i;
  assign ovr[1]  = rd_b_sys_i;
  assign ovr[2]  = wr_sys_i;

  for (genvar p = 0; p < NPORT; p++) begin : g_dec
    bankreg_decode u_dec (
      .code_i  (code[p]),
      .kernel_i(kernel),
      .sys_i   (ovr[p]),
      .sel_o   (sel[p])
    );
  end

  bankreg_gpr_bank #(.N(BANK_N), .W(DATA_W)) u_shared (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i && sel[2].bank == BANK_SHARED),
    .wr_idx_i  (sel[2].idx),
    .wr_data_i (wr_data_i),
    .rd_a_idx_i(sel[0].idx),
    .rd_b_idx_i(sel[1].idx),
    .rd_a_o    (shr_a),
    .rd_b_o    (shr_b)
  );

  bankreg_gpr_bank #(.N(BANK_N), .W(DATA_W)) u_user (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i && sel[2].bank == BANK_USER),
    .wr_idx_i  (sel[2].idx),
    .wr_data_i (wr_data_i),
    .rd_a_idx_i(sel[0].idx),
    .rd_b_idx_i(sel[1].idx),
    .rd_a_o    (usr_a),
    .rd_b_o    (usr_b)
  );

  bankreg_sys_bank u_sys (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i && sel[2].bank == BANK_SYS),
    .wr_idx_i  (sel[2].idx),
    .wr_data_i (wr_data_i),
    .ip_load_i (ip_load_i),
    .ip_data_i (ip_data_i),
    .seg_wr_i  (seg_wr_i),
    .seg_data_i(seg_data_i),
    .rd_a_idx_i(sel[0].idx),
    .rd_b_idx_i(sel[1].idx),
    .rd_a_o    (sys_a),
    .rd_b_o    (sys_b),
    .ip_o      (ip_o),
    .status_o  (status_o)
  );

  always_comb begin
    unique case (sel[0].bank)
      BANK_SHARED: rd_a_data_o = shr_a;
      BANK_USER:   rd_a_data_o = usr_a;
      default:     rd_a_data_o = sys_a;
    endcase
    unique case (sel[1].bank)
      BANK_SHARED: rd_b_data_o = shr_b;
      BANK_USER:   rd_b_data_o = usr_b;
      default:     rd_b_data_o = sys_b;
    endcase
  end
endmodule

// File: rtl/bankreg_file_chk.sv
module bankreg_file_chk
  import bankreg_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CODE_W-1:0] rd_a_addr_i,
  input logic              rd_a_sys_i,
  input logic [DATA_W-1:0] rd_a_data_o,
  input logic [CODE_W-1:0] rd_b_addr_i,
  input logic              rd_b_sys_i,
  input logic [DATA_W-1:0] rd_b_data_o,
  input logic              wr_en_i,
  input logic [CODE_W-1:0] wr_addr_i,
  input logic              wr_sys_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              ip_load_i,
  input logic [IP_W-1:0]   ip_data_i,
  input logic              seg_wr_i,
  input logic [SEG_W-1:0]  seg_data_i,
  input logic [IP_W-1:0]   ip_o,
  input logic [DATA_W-1:0] status_o
);
  logic wr_sys_ok, st_wr, ip_wr;
  assign wr_sys_ok = status_o[MODE_BIT] || wr_sys_i;
  assign st_wr     = wr_en_i && wr_addr_i == 3'd7 && wr_sys_ok;
  assign ip_wr     = wr_en_i && wr_addr_i == 3'd4 && wr_sys_ok;

  // R2
  kernel_status_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[MODE_BIT] && rd_a_addr_i == 3'd7) |-> rd_a_data_o == status_o);

  // R2
  kernel_ip_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[MODE_BIT] && rd_b_addr_i == 3'd4) |-> rd_b_data_o == ip_o[DATA_W-1:0]);

  // R4
  override_status_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_sys_i && rd_a_addr_i == 3'd7) |-> rd_a_data_o == status_o);

  // R4
  override_ip_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_b_sys_i && rd_b_addr_i == 3'd4) |-> rd_b_data_o == ip_o[DATA_W-1:0]);

  // R6
  ip_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ip_load_i |=> ip_o == $past(ip_data_i));

  // R6
  ip_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ip_load_i && !ip_wr) |=> $stable(ip_o));

  // R7
  seg_field_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_wr_i |=> status_o[SEG_W-1:0] == $past(seg_data_i));

  // R7
  seg_upper_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_wr_i && !st_wr) |=> $stable(status_o[DATA_W-1:SEG_W]));

  // R5
  status_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_wr && !seg_wr_i) |=> status_o == $past(wr_data_i));

  // R5
  status_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!st_wr && !seg_wr_i) |=> $stable(status_o));
endmodule

bind bankreg_file bankreg_file_chk u_chk (.*);

// File: tb/bankreg_file_test.sv
module bankreg_file_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 17;
  localparam int WDOG = 5000;

  // {we, waddr, wsys, wdata, raddr, rsys, expected read A before the edge}
  localparam logic [40:0] VECS [NVEC] = '{
    {1'b1, 3'd0, 1'b0, 16'h1111, 3'd0, 1'b0, 16'h0000}, // R8 old value
    {1'b1, 3'd1, 1'b0, 16'h2222, 3'd0, 1'b0, 16'h1111}, // R1
    {1'b1, 3'd5, 1'b0, 16'h5555, 3'd7, 1'b0, 16'h1000}, // R2 status
    {1'b1, 3'd6, 1'b0, 16'h6666, 3'd5, 1'b0, 16'h5555}, // R2 sp
    {1'b1, 3'd4, 1'b0, 16'h4444, 3'd6, 1'b0, 16'h6666}, // R2 ra
    {1'b0, 3'd0, 1'b0, 16'h0000, 3'd4, 1'b0, 16'h4444}, // R2 ip low
    {1'b1, 3'd7, 1'b0, 16'h0A00, 3'd7, 1'b0, 16'h1000}, // R5 to user, R8
    {1'b1, 3'd5, 1'b0, 16'hBEEF, 3'd5, 1'b0, 16'h0000}, // R3
    {1'b0, 3'd0, 1'b0, 16'h0000, 3'd5, 1'b0, 16'hBEEF}, // R3
    {1'b0, 3'd0, 1'b0, 16'h0000, 3'd5, 1'b1, 16'h5555}, // R4
    {1'b0, 3'd0, 1'b0, 16'h0000, 3'd7, 1'b1, 16'h0A00}, // R4
    {1'b1, 3'd6, 1'b1, 16'h7777, 3'd6, 1'b0, 16'h0000}, // R4 write
    {1'b0, 3'd0, 1'b0, 16'h0000, 3'd6, 1'b1, 16'h7777}, // R4
    {1'b0, 3'd0, 1'b0, 16'h0000, 3'd1, 1'b0, 16'h2222}, // R1 user
    {1'b1, 3'd7, 1'b1, 16'h1300, 3'd0, 1'b0, 16'h1111}, // R5 to kernel
    {1'b0, 3'd0, 1'b0, 16'h0000, 3'd5, 1'b0, 16'h5555}, // R2
    {1'b0, 3'd0, 1'b0, 16'h0000, 3'd7, 1'b0, 16'h1300}  // R5
  };

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [2:0]  rd_a_addr_i = '0, rd_b_addr_i = '0, wr_addr_i = '0;
  logic        rd_a_sys_i = 1'b0, rd_b_sys_i = 1'b0, wr_sys_i = 1'b0, wr_en_i = 1'b0;
  logic [15:0] wr_data_i = '0, rd_a_data_o, rd_b_data_o, status_o;
  logic        ip_load_i = 1'b0, seg_wr_i = 1'b0;
  logic [23:0] ip_data_i = '0, ip_o;
  logic [7:0]  seg_data_i = '0;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bankreg_file uut (.*);

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en_i = 1'b0; wr_sys_i = 1'b0; ip_load_i = 1'b0; seg_wr_i = 1'b0;
    rd_a_sys_i = 1'b0; rd_b_sys_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < WDOG; c++) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=expired expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (2) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    #1;
    chk("R9 status", {8'h0, status_o}, 24'h001000);
    chk("R9 ip", ip_o, 24'h0);
    chk("R9 shared", {8'h0, rd_a_data_o}, 24'h0);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk_i);
      {wr_en_i, wr_addr_i, wr_sys_i, wr_data_i, rd_a_addr_i, rd_a_sys_i} = VECS[i][40:16];
      #1 chk($sformatf("R1-vector %0d", i), {8'h0, rd_a_data_o}, {8'h0, VECS[i][15:0]});
    end
    @(negedge clk_i) idle();

    // R10: independent read ports
    rd_a_addr_i = 3'd0; rd_b_addr_i = 3'd5;
    #1 chk("R10 port A", {8'h0, rd_a_data_o}, 24'h001111);
    chk("R10 port B", {8'h0, rd_b_data_o}, 24'h005555);
    rd_a_addr_i = 3'd6; rd_b_addr_i = 3'd6;
    #1 chk("R10 same code", {rd_a_data_o[7:0], rd_b_data_o}, 24'h777777);

    // R6: full load then partial port write
    @(negedge clk_i) begin ip_load_i = 1'b1; ip_data_i = 24'hABCDEF; end
    @(negedge clk_i) idle();
    #1 chk("R6 full load", ip_o, 24'hABCDEF);
    rd_a_addr_i = 3'd4;
    #1 chk("R6 low read", {8'h0, rd_a_data_o}, 24'h00CDEF);
    wr_en_i = 1'b1; wr_addr_i = 3'd4; wr_data_i = 16'h1234;
    @(negedge clk_i) idle();
    #1 chk("R6 port write low", ip_o, 24'hAB1234);
    // R11: load beats port write
    ip_load_i = 1'b1; ip_data_i = 24'h000001;
    wr_en_i = 1'b1; wr_addr_i = 3'd4; wr_data_i = 16'hFFFF;
    @(negedge clk_i) idle();
    #1 chk("R11 ip priority", ip_o, 24'h000001);

    // R7: segment only
    seg_wr_i = 1'b1; seg_data_i = 8'h5A;
    @(negedge clk_i) idle();
    #1 chk("R7 segment", {8'h0, status_o}, 24'h00135A);
    // R11: status write with segment write
    wr_en_i = 1'b1; wr_addr_i = 3'd7; wr_data_i = 16'h9200;
    seg_wr_i = 1'b1; seg_data_i = 8'h77;
    @(negedge clk_i) idle();
    #1 chk("R11 status merge", {8'h0, status_o}, 24'h009277);

    // R5: clearing mode bit switches to user bank
    wr_en_i = 1'b1; wr_addr_i = 3'd7; wr_data_i = 16'h0000;
    rd_a_addr_i = 3'd5;
    #1 chk("R5 before switch", {8'h0, rd_a_data_o}, 24'h005555);
    @(negedge clk_i) idle();
    #1 chk("R5 after switch", {8'h0, rd_a_data_o}, 24'h00BEEF);
    chk("R5 mode bit", {23'h0, status_o[12]}, 24'h0);

    // R9: asynchronous reset mid-run
    rst_ni = 1'b0;
    #1 chk("R9 async status", {8'h0, status_o}, 24'h001000);
    chk("R9 async ip", ip_o, 24'h0);
    @(negedge clk_i) rst_ni = 1'b1;
    rd_a_addr_i = 3'd0; rd_b_addr_i = 3'd5;
    #1 chk("R9 shared cleared", {8'h0, rd_a_data_o}, 24'h0);
    chk("R9 sp cleared", {8'h0, rd_b_data_o}, 24'h0);
    wr_en_i = 1'b1; wr_addr_i = 3'd7; wr_data_i = 16'h0000;
    @(negedge clk_i) idle();
    #1 chk("R9 user cleared", {8'h0, rd_b_data_o}, 24'h0);

    done = 1'b1;
    finish_run();
  end
endmodule